// File: doc/BRIEF.md
# Ethernet Controller Command, Interrupt and Timer Unit

This block is the control-register core of a descriptor-driven Ethernet controller. It holds a 16-bit command register. Some of its bits start work in the transmit, receive-resource and address-filter-load engines, and those bits clear themselves when the work is done. It also holds an interrupt mask register, an interrupt status register, a data configuration register and a 32-bit down-counting general-purpose timer that software sees as two 16-bit halves. DMA and the packet datapaths sit outside this block.

Software uses a single-cycle register write port and a combinational read port. The engines report completions and faults as single-cycle pulses on an event vector, and each pulse sets the matching status bit. The block drives a level interrupt and one-cycle start pulses back to the engines. A clock-enable input supplies the timer's 5 MHz tick.

Register addresses: 0 command, 1 configuration, 2 interrupt mask, 3 interrupt status, 4 timer low half, 5 timer high half. Other addresses read as zero and ignore writes.

Top module: `nic_ctl_core`

## Requirements
- R1: After the asynchronous reset the command register reads 0x0094 (reset-mode bit 7, stop-timer bit 4, receiver-disable bit 2). Mask, status, configuration and both timer halves read 0, and `irq` is low.
- R2: While reset mode (command bit 7) is set, a command write that has bit 7 clear only clears bit 7. Every other bit of that write is ignored.
- R3: Outside reset mode, a command write ORs in only the bits in 0x03BF. Bit 6 can never be set. The read-resource bit 8 is never stored and always reads 0.
- R4: Writing receiver-enable (bit 3) clears receiver-disable (bit 2), and writing bit 2 clears bit 3, so writing both clears both. Start-timer (bit 5) and stop-timer (bit 4) behave the same way. `rx_on` follows bit 3.
- R5: A command write with bit 7 set clears bits 9, 8, 1 and 0, sets bits 7 and 2, and issues no engine start pulse.
- R6: An accepted command write with bit 1 (transmit) or bit 9 (load address filter) sets that bit and pulses `tx_go` or `cam_go` for one cycle, in the cycle after the write. Bit 8 pulses `fetch_go` the same way. Bit 1 clears on the transmit-done event (status bit 9), and bit 9 clears on the filter-load-done event (status bit 12).
- R7: A mask write keeps only bits 14:0. `irq` is high exactly when mask AND status is nonzero.
- R8: A status write clears the written 1-bits that are currently set. If an event sets a bit in the same cycle as a clear of that bit, the bit stays set.
- R9: Clearing the buffers-exhausted status bit (0x0020) with a status write pulses `fetch_go` in the next cycle. Writing that bit when it is already clear does nothing.
- R10: Event pulses set status bits only inside 0x1EF0. These are filter-load done 0x1000, programmable 0x0800, packet received 0x0400, transmit done 0x0200, timer complete 0x0080, descriptors exhausted 0x0040, buffers exhausted 0x0020 and buffer area exceeded 0x0010.
- R11: While stop-timer is clear, each cycle with `tick_en` high decrements the 32-bit count {high, low} by one. While stop-timer is set the count is frozen.
- R12: A tick at count 0 reloads 0xFFFFFFFF and sets timer-complete status 0x0080.
- R13: A write to either timer half loads that half at once, and it wins over a tick in the same cycle.
- R14: The configuration register accepts a write only in reset mode, and the value is ANDed with 0xBFFF. At other times writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| evt_set | input | 16 | Single-cycle event pulses, one per status bit |
| tick_en | input | 1 | Timer tick enable (5 MHz rate) |
| irq | output | 1 | Level interrupt |
| tx_go | output | 1 | Transmit engine start pulse |
| fetch_go | output | 1 | Receive-resource fetch pulse |
| cam_go | output | 1 | Address-filter load start pulse |
| rx_on | output | 1 | Receiver enabled |
| cfg_out | output | 16 | Data configuration register value |

## Verification
The checker watches several rules on every cycle. Leaving reset mode touches only bit 7. Start-timer and stop-timer are never both set. A write carrying the reset bit starts no engine. Event pulses always land in status. The timer stays frozen under stop-timer and reloads with timer-complete at underflow. The configuration register never moves outside reset mode. Other behaviours need the bench's ordered scenarios because they depend on history and exact register values: the enable/disable cancellation, the mask on command writes, write-one-to-clear with an event in the same cycle, the fetch triggered by clearing buffers-exhausted, and the timer half-write winning over a tick.

// File: rtl/nic_ctl_pkg.sv
package nic_ctl_pkg;
   // register addresses
   localparam logic [2:0] A_CMD  = 3'd0;
   localparam logic [2:0] A_CFG  = 3'd1;
   localparam logic [2:0] A_MASK = 3'd2;
   localparam logic [2:0] A_STAT = 3'd3;
   localparam logic [2:0] A_TLO  = 3'd4;
   localparam logic [2:0] A_THI  = 3'd5;

   // command bit positions
   localparam int C_HALT   = 0;
   localparam int C_TX     = 1;
   localparam int C_RXOFF  = 2;
   localparam int C_RXON   = 3;
   localparam int C_TSTOP  = 4;
   localparam int C_TSTART = 5;
   localparam int C_RST    = 7;
   localparam int C_FETCH  = 8;
   localparam int C_CAM    = 9;

   // status bit positions
   localparam int S_BUFX  = 5;
   localparam int S_TMR   = 7;
   localparam int S_TXDN  = 9;
   localparam int S_CAMDN = 12;

   localparam logic [15:0] CMD_WMASK  = 16'h03BF;
   localparam logic [15:0] CMD_RSTVAL = 16'h0094;
   localparam logic [15:0] MASK_KEEP  = 16'h7FFF;
   localparam logic [15:0] STAT_EVT   = 16'h1EF0;
endpackage

// File: rtl/nic_ctl_cmd.sv
module nic_ctl_cmd
   import nic_ctl_pkg::*;
#(
   parameter int REG_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_wr,
   input  logic [REG_W-1:0] wdata,
   input  logic             tx_done,
   input  logic             cam_done,
   input  logic             fetch_req,
   output logic [REG_W-1:0] cmd_q,
   output logic             tx_go,
   output logic             cam_go,
   output logic             fetch_go
);
   logic [REG_W-1:0] nxt;
   logic             tx_n, cam_n, fetch_n;
   logic             leave_only;

   assign leave_only = cmd_q[C_RST] && !wdata[C_RST];

   always_comb begin
      nxt     = cmd_q;
      tx_n    = 1'b0;
      cam_n   = 1'b0;
      fetch_n = fetch_req;
      if (tx_done)  nxt[C_TX]  = 1'b0;
      if (cam_done) nxt[C_CAM] = 1'b0;
      if (cmd_wr) begin
         if (leave_only) begin
            nxt[C_RST] = 1'b0;
         end else begin
            nxt          = nxt | (wdata & CMD_WMASK);
            nxt[C_FETCH] = 1'b0;
            if (wdata[C_RXOFF])  nxt[C_RXON]   = 1'b0;
            if (wdata[C_RXON])   nxt[C_RXOFF]  = 1'b0;
            if (wdata[C_TSTOP])  nxt[C_TSTART] = 1'b0;
            if (wdata[C_TSTART]) nxt[C_TSTOP]  = 1'b0;
            if (wdata[C_RST]) begin
               nxt[C_CAM]   = 1'b0;
               nxt[C_TX]    = 1'b0;
               nxt[C_HALT]  = 1'b0;
               nxt[C_RST]   = 1'b1;
               nxt[C_RXOFF] = 1'b1;
            end else begin
               tx_n    = wdata[C_TX];
               cam_n   = wdata[C_CAM];
               fetch_n = fetch_req | wdata[C_FETCH];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q    <= CMD_RSTVAL;
         tx_go    <= 1'b0;
         cam_go   <= 1'b0;
         fetch_go <= 1'b0;
      end else begin
         cmd_q    <= nxt;
         tx_go    <= tx_n;
         cam_go   <= cam_n;
         fetch_go <= fetch_n;
      end
   end
endmodule

// File: rtl/nic_ctl_irq.sv
module nic_ctl_irq
   import nic_ctl_pkg::*;
#(
   parameter int REG_W   = 16,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mask_wr,
   input  logic             stat_wr,
   input  logic [REG_W-1:0] wdata,
   input  logic [REG_W-1:0] evt_set,
   input  logic             tmr_evt,
   output logic [REG_W-1:0] mask_q,
   output logic [REG_W-1:0] stat_q,
   output logic             irq,
   output logic             bufx_clr
);
   logic [REG_W-1:0] clr, tmr_bit, stat_n;
   logic             hit;

   assign clr      = stat_wr ? (wdata & stat_q) : '0;
   assign bufx_clr = clr[S_BUFX];
   always_comb begin
      tmr_bit        = '0;
      tmr_bit[S_TMR] = tmr_evt;
   end
   // an event in the same cycle as a clear keeps the bit set
   assign stat_n = (stat_q & ~clr) | (evt_set & STAT_EVT) | tmr_bit;
   assign hit    = |(mask_q & stat_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         stat_q <= '0;
      end else begin
         if (mask_wr) mask_q <= wdata & MASK_KEEP;
         stat_q <= stat_n;
      end
   end

   generate
      if (IRQ_REG) begin : g_irq_ff
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= hit;
         end
         assign irq = irq_q;
      end else begin : g_irq_comb
         assign irq = hit;
      end
   endgenerate
endmodule

// File: rtl/nic_ctl_timer.sv
module nic_ctl_timer #(
   parameter int REG_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         half_wr,
   input  logic [REG_W-1:0]   wdata,
   input  logic               tick_en,
   input  logic               run,
   output logic [2*REG_W-1:0] count_q,
   output logic               tmr_evt
);
   localparam int TMR_W = 2 * REG_W;
   localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

   assign tmr_evt = tick_en && run && (half_wr == 2'b00) && (count_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q <= '0;
      end else if (|half_wr) begin
         for (int h = 0; h < 2; h++)
            if (half_wr[h]) count_q[h*REG_W +: REG_W] <= wdata;
      end else if (tick_en && run) begin
         count_q <= tmr_evt ? '1 : count_q - ONE;
      end
   end
endmodule

// File: rtl/nic_ctl_core.sv
module nic_ctl_core
   import nic_ctl_pkg::*;
#(
   parameter int          REG_W    = 16,
   parameter bit          IRQ_REG  = 1'b0,
   parameter logic [15:0] CFG_KEEP = 16'hBFFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       addr,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   input  logic [REG_W-1:0] evt_set,
   input  logic             tick_en,
   output logic             irq,
   output logic             tx_go,
   output logic             fetch_go,
   output logic             cam_go,
   output logic             rx_on,
   output logic [REG_W-1:0] cfg_out
);
   localparam int TMR_W = 2 * REG_W;

   if (REG_W != 16) begin : g_bad_width
      $error("nic_ctl_core: REG_W must be 16");
   end

   logic [REG_W-1:0] cmd_q, mask_q, stat_q, cfg_q;
   logic [TMR_W-1:0] count_q;
   logic             bufx_clr, tmr_evt;
   logic [1:0]       half_wr;

   assign half_wr = {wr_en && addr == A_THI, wr_en && addr == A_TLO};

   nic_ctl_cmd #(.REG_W(REG_W)) u_cmd (
      .clk(clk), .rst_n(rst_n),
      .cmd_wr(wr_en && addr == A_CMD), .wdata(wdata),
      .tx_done(evt_set[S_TXDN]), .cam_done(evt_set[S_CAMDN]),
      .fetch_req(bufx_clr),
      .cmd_q(cmd_q), .tx_go(tx_go), .cam_go(cam_go), .fetch_go(fetch_go)
   );

   nic_ctl_irq #(.REG_W(REG_W), .IRQ_REG(IRQ_REG)) u_irq (
      .clk(clk), .rst_n(rst_n),
      .mask_wr(wr_en && addr == A_MASK), .stat_wr(wr_en && addr == A_STAT),
      .wdata(wdata), .evt_set(evt_set), .tmr_evt(tmr_evt),
      .mask_q(mask_q), .stat_q(stat_q), .irq(irq), .bufx_clr(bufx_clr)
   );

   nic_ctl_timer #(.REG_W(REG_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .half_wr(half_wr), .wdata(wdata),
      .tick_en(tick_en), .run(!cmd_q[C_TSTOP]),
      .count_q(count_q), .tmr_evt(tmr_evt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                    cfg_q <= '0;
      else if (wr_en && addr == A_CFG && cmd_q[C_RST]) cfg_q <= wdata & CFG_KEEP;
   end

   always_comb begin
      case (addr)
         A_CMD:   rdata = cmd_q;
         A_CFG:   rdata = cfg_q;
         A_MASK:  rdata = mask_q;
         A_STAT:  rdata = stat_q;
         A_TLO:   rdata = count_q[REG_W-1:0];
         A_THI:   rdata = count_q[TMR_W-1:REG_W];
         default: rdata = '0;
      endcase
   end

   assign rx_on   = cmd_q[C_RXON];
   assign cfg_out = cfg_q;
endmodule

// File: rtl/nic_ctl_core_chk.sv
module nic_ctl_core_chk
   import nic_ctl_pkg::*;
#(
   parameter int REG_W = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic [2:0]         addr,
   input logic [REG_W-1:0]   wdata,
   input logic [REG_W-1:0]   evt_set,
   input logic               tick_en,
   input logic               tx_go,
   input logic               cam_go,
   input logic [REG_W-1:0]   cmd_q,
   input logic [REG_W-1:0]   stat_q,
   input logic [REG_W-1:0]   cfg_q,
   input logic [2*REG_W-1:0] count_q
);
   logic tmr_wr;
   assign tmr_wr = wr_en && (addr == A_TLO || addr == A_THI);

   AST_LEAVE_RESET_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_CMD && cmd_q[C_RST] && !wdata[C_RST])
      |=> (cmd_q == ($past(cmd_q) & 16'hFF7F))); // R2

   AST_TIMER_PAIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_q[C_TSTOP] && cmd_q[C_TSTART])); // R4

   AST_RESET_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_CMD && wdata[C_RST]) |=> (!tx_go && !cam_go)); // R5

   AST_EVENT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt_set & STAT_EVT))
      |=> ((stat_q & $past(evt_set & STAT_EVT)) == $past(evt_set & STAT_EVT))); // R8

   AST_TIMER_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q[C_TSTOP] && !tmr_wr) |=> $stable(count_q)); // R11

   AST_TIMER_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_en && !cmd_q[C_TSTOP] && count_q == '0 && !tmr_wr)
      |=> (count_q == '1 && stat_q[S_TMR])); // R12

   AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_q[C_RST] |=> $stable(cfg_q)); // R14
endmodule

bind nic_ctl_core nic_ctl_core_chk #(.REG_W(REG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
   .evt_set(evt_set), .tick_en(tick_en), .tx_go(tx_go), .cam_go(cam_go),
   .cmd_q(cmd_q), .stat_q(stat_q), .cfg_q(cfg_q), .count_q(count_q)
);

// File: tb/nic_ctl_core_bench.sv
`timescale 1ns/1ps
module nic_ctl_core_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  addr = 3'd0;
   logic [15:0] wdata = 16'h0;
   logic [15:0] evt_set = 16'h0;
   logic        tick_en = 1'b0;
   logic [15:0] rdata, cfg_out;
   logic        irq, tx_go, fetch_go, cam_go, rx_on;

   always #2 clk = ~clk;

   nic_ctl_core u_nic_ctl_core (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .evt_set(evt_set), .tick_en(tick_en), .irq(irq),
      .tx_go(tx_go), .fetch_go(fetch_go), .cam_go(cam_go), .rx_on(rx_on),
      .cfg_out(cfg_out)
   );

   int n_chk = 0, n_err = 0;
   int cnt_tx = 0, cnt_cam = 0, cnt_fetch = 0;
   bit done = 1'b0;

   // behavioural reference state
   logic [15:0] m_cmd = 16'h0094, m_cfg = 0, m_mask = 0, m_stat = 0;
   logic [31:0] m_cnt = 0;
   logic        m_tx = 0, m_cam = 0, m_fetch = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] m_read(input logic [2:0] a);
      case (a)
         3'd0: return m_cmd;
         3'd1: return m_cfg;
         3'd2: return m_mask;
         3'd3: return m_stat;
         3'd4: return m_cnt[15:0];
         3'd5: return m_cnt[31:16];
         default: return 16'h0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cmd = 16'h0094; m_cfg = 0; m_mask = 0; m_stat = 0; m_cnt = 0;
         m_tx = 0; m_cam = 0; m_fetch = 0;
      end else begin
         logic [15:0] c, clr;
         logic tx, cam, fe, tc;
         tx = 0; cam = 0; fe = 0; tc = 0;
         c = m_cmd;
         if (evt_set[9])  c = c & ~16'h0002;
         if (evt_set[12]) c = c & ~16'h0200;
         if (wr_en && addr == 3'd0) begin
            if (m_cmd[7] && !wdata[7]) c = c & ~16'h0080;
            else begin
               c = (c | (wdata & 16'h03BF)) & ~16'h0100;
               if (wdata[2]) c = c & ~16'h0008;
               if (wdata[3]) c = c & ~16'h0004;
               if (wdata[4]) c = c & ~16'h0020;
               if (wdata[5]) c = c & ~16'h0010;
               if (wdata[7]) c = (c & ~16'h0303) | 16'h0084;
               else begin tx = wdata[1]; cam = wdata[9]; fe = wdata[8]; end
            end
         end
         if (wr_en && addr == 3'd1 && m_cmd[7]) m_cfg = wdata & 16'hBFFF;
         if (wr_en && addr == 3'd2) m_mask = wdata & 16'h7FFF;
         if (wr_en && addr == 3'd4) m_cnt[15:0] = wdata;
         else if (wr_en && addr == 3'd5) m_cnt[31:16] = wdata;
         else if (tick_en && !m_cmd[4]) begin
            if (m_cnt == 0) begin m_cnt = 32'hFFFF_FFFF; tc = 1; end
            else m_cnt = m_cnt - 1;
         end
         clr = (wr_en && addr == 3'd3) ? (wdata & m_stat) : 16'h0;
         if (clr[5]) fe = 1;
         m_stat = (m_stat & ~clr) | (evt_set & 16'h1EF0) | (tc ? 16'h0080 : 16'h0);
         m_cmd = c; m_tx = tx; m_cam = cam; m_fetch = fe;
      end
   end

   // per-cycle comparison against the reference, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         string t;
         case (addr)
            3'd0: t = "R3 rdata(cmd)";
            3'd1: t = "R14 rdata(cfg)";
            3'd2: t = "R7 rdata(mask)";
            3'd3: t = "R8 rdata(status)";
            default: t = "R11 rdata(timer)";
         endcase
         chk(t, rdata, m_read(addr));
         chk("R7 irq", irq, |(m_mask & m_stat));
         chk("R6 tx_go", tx_go, m_tx);
         chk("R6 cam_go", cam_go, m_cam);
         chk("R9 fetch_go", fetch_go, m_fetch);
         chk("R4 rx_on", rx_on, m_cmd[3]);
         chk("R14 cfg_out", cfg_out, m_cfg);
         if (tx_go) cnt_tx++;
         if (cam_go) cnt_cam++;
         if (fetch_go) cnt_fetch++;
      end
   end

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk); #1 wr_en = 1; addr = a; wdata = d;
      @(negedge clk); #1 wr_en = 0;
   endtask

   task automatic wr_evt(input logic [2:0] a, input logic [15:0] d, input logic [15:0] e);
      @(negedge clk); #1 wr_en = 1; addr = a; wdata = d; evt_set = e;
      @(negedge clk); #1 wr_en = 0; evt_set = 0;
   endtask

   task automatic wr_tick(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk); #1 wr_en = 1; addr = a; wdata = d; tick_en = 1;
      @(negedge clk); #1 wr_en = 0; tick_en = 0;
   endtask

   task automatic evt(input logic [15:0] e);
      @(negedge clk); #1 evt_set = e;
      @(negedge clk); #1 evt_set = 0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #1 tick_en = 1;
         @(negedge clk); #1 tick_en = 0;
      end
   endtask

   task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
      @(negedge clk); #1 addr = a;
      @(negedge clk); chk(tag, rdata, exp);
   endtask

   task automatic settle;
      @(negedge clk); #1;
   endtask

   initial begin
      #(4 * 150000);
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      int t0;
      repeat (3) @(negedge clk);
      #1 rst_n = 1;
      // R1 reset state
      rd(3'd0, 16'h0094, "R1 cmd after reset");
      rd(3'd2, 16'h0000, "R1 mask after reset");
      rd(3'd3, 16'h0000, "R1 status after reset");
      rd(3'd1, 16'h0000, "R1 cfg after reset");
      rd(3'd4, 16'h0000, "R1 timer low after reset");
      chk("R1 irq after reset", irq, 1'b0);
      // R14 cfg writable in reset mode, masked
      wr(3'd1, 16'hFFFF);
      rd(3'd1, 16'hBFFF, "R14 cfg masked write");
      // R2 write without reset bit only leaves reset
      wr(3'd0, 16'h0008);
      rd(3'd0, 16'h0014, "R2 leave reset only");
      wr(3'd1, 16'h1234);
      rd(3'd1, 16'hBFFF, "R14 cfg locked");
      // R4 pairs
      wr(3'd0, 16'h0008);
      rd(3'd0, 16'h0018, "R4 rx enable clears disable");
      chk("R4 rx_on high", rx_on, 1'b1);
      wr(3'd0, 16'h000C);
      rd(3'd0, 16'h0010, "R4 both cancel");
      // R3 unwritable bit 6
      wr(3'd0, 16'h0040);
      rd(3'd0, 16'h0010, "R3 bit6 ignored");
      // R6 transmit
      t0 = cnt_tx;
      wr(3'd0, 16'h0002); settle();
      chk("R6 tx pulse count", cnt_tx - t0, 1);
      rd(3'd0, 16'h0012, "R6 tx bit held");
      evt(16'h0200);
      rd(3'd0, 16'h0010, "R6 tx bit cleared by done");
      rd(3'd3, 16'h0200, "R10 tx done status");
      // R7 mask
      wr(3'd2, 16'hFFFF);
      rd(3'd2, 16'h7FFF, "R7 mask bit15 dropped");
      chk("R7 irq high", irq, 1'b1);
      wr(3'd3, 16'h0200);
      rd(3'd3, 16'h0000, "R8 w1c");
      chk("R7 irq low", irq, 1'b0);
      // R10 event mask
      evt(16'hFFFF);
      rd(3'd3, 16'h1EF0, "R10 event bits");
      // R9 fetch on buffers-exhausted clear
      t0 = cnt_fetch;
      wr(3'd3, 16'h0020); settle();
      chk("R9 fetch on clear", cnt_fetch - t0, 1);
      rd(3'd3, 16'h1ED0, "R9 status after clear");
      t0 = cnt_fetch;
      wr(3'd3, 16'h0020); settle();
      chk("R9 no fetch when clear", cnt_fetch - t0, 0);
      // R8 event wins over clear
      wr_evt(3'd3, 16'h0400, 16'h0400);
      rd(3'd3, 16'h1ED0, "R8 event beats clear");
      // R6 filter load
      t0 = cnt_cam;
      wr(3'd0, 16'h0200); settle();
      chk("R6 cam pulse count", cnt_cam - t0, 1);
      rd(3'd0, 16'h0210, "R6 cam bit held");
      evt(16'h1000);
      rd(3'd0, 16'h0010, "R6 cam bit cleared by done");
      // R3 / R6 read-resource
      t0 = cnt_fetch;
      wr(3'd0, 16'h0100); settle();
      chk("R6 fetch pulse from command", cnt_fetch - t0, 1);
      rd(3'd0, 16'h0010, "R3 fetch bit reads zero");
      // R5 software reset
      wr(3'd0, 16'h0003);
      rd(3'd0, 16'h0013, "R6 halt and tx held");
      t0 = cnt_tx + cnt_cam + cnt_fetch;
      wr(3'd0, 16'h0380); settle();
      chk("R5 no pulses on reset", cnt_tx + cnt_cam + cnt_fetch - t0, 0);
      rd(3'd0, 16'h0094, "R5 software reset value");
      wr(3'd1, 16'h4001);
      rd(3'd1, 16'h0001, "R14 cfg written in soft reset");
      wr(3'd0, 16'h0000);
      rd(3'd0, 16'h0014, "R2 leave soft reset");
      wr(3'd3, 16'hFFFF);
      rd(3'd3, 16'h0000, "R8 clear all");
      wr(3'd2, 16'h0080);
      // R11 / R12 / R13 timer
      wr(3'd4, 16'h0003);
      wr(3'd5, 16'h0000);
      ticks(5);
      rd(3'd4, 16'h0003, "R11 frozen while stopped");
      wr(3'd0, 16'h0020);
      rd(3'd0, 16'h0024, "R4 start clears stop");
      ticks(2);
      rd(3'd4, 16'h0001, "R11 countdown");
      ticks(1);
      rd(3'd4, 16'h0000, "R11 reached zero");
      chk("R7 irq idle before underflow", irq, 1'b0);
      ticks(1);
      rd(3'd5, 16'hFFFF, "R12 reload high");
      rd(3'd4, 16'hFFFF, "R12 reload low");
      rd(3'd3, 16'h0080, "R12 timer complete");
      chk("R7 irq from timer", irq, 1'b1);
      wr_tick(3'd4, 16'h0100);
      rd(3'd4, 16'h0100, "R13 write beats tick");
      rd(3'd5, 16'hFFFF, "R13 high untouched");
      wr(3'd5, 16'h0000);
      ticks(1);
      rd(3'd4, 16'h00FF, "R11 tick after load");
      wr(3'd0, 16'h0010);
      rd(3'd0, 16'h0014, "R4 stop clears start");
      ticks(3);
      rd(3'd4, 16'h00FF, "R11 stopped again");
      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule